// File: doc/BRIEF.md
# Serial Receive Queue with Event Interrupts

This block is the receive half of an asynchronous serial port. It watches an incoming line that it samples on a tick at sixteen times the bit rate. It assembles characters of 5 to 8 data bits, with optional parity and 1 or 2 stop bits. Each completed character goes into a 16-entry queue as a 12-bit word. The word holds the data byte and, beside it, that character's own break, parity-error and framing-error flags.

The host reads the word at the head of the queue and pops it with a one-cycle strobe. It sets a fill threshold, a timeout in character times and a mask for each of three receive events: overrun, fill above threshold and stale data. It reads the raw event status, and a single interrupt line combines the unmasked events. An overrun stays flagged until the host clears the queue. Reading data never clears it.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: After reset the queue is empty, `not_empty_o` is 0, `rd_word_o` is 0, all three status bits are 0 and `irq_o` is 0.
- R2: `char_len_i` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data arrives LSB first and appears in `rd_word_o[7:0]`, with the unused upper bits zero.
- R3: With `par_en_i` set, a parity bit follows the data. `par_odd_i`=1 expects odd parity over data plus parity bit, and 0 expects even. A mismatch sets `rd_word_o[9]`.
- R4: `two_stop_i` selects 2 stop bits instead of 1. A stop bit sampled low sets the framing-error flag `rd_word_o[10]`.
- R5: A frame whose data, parity and first stop bit all sample low is stored as one entry with data 0x00 and the break flag `rd_word_o[8]` set, with no framing or parity flag. No further character starts until the line has returned high.
- R6: The start bit is re-sampled 8 ticks after the falling edge. If the line is high again at that point, it is rejected and nothing is stored.
- R7: The queue holds 16 entries and returns them in arrival order. While an entry is present, `not_empty_o` is 1 and `rd_word_o[11]` (valid) is 1. `pop_i` removes the head entry.
- R8: A character that completes while the queue is full is dropped, and `irq_stat_o[0]` (overrun) is set. That bit stays set through pops and is cleared only by `fifo_rst_i`.
- R9: `irq_stat_o[1]` is 1 whenever the number of stored entries is greater than `thresh_i`.
- R10: `irq_stat_o[2]` (timeout) sets once the queue has been non-empty with no push or pop for `tmo_chars_i` character times. A character time is 16 ticks per bit of the configured frame. It clears on a pop or when the queue empties, and a value of 0 disables it.
- R11: `irq_o` is 1 exactly when some status bit and the matching `irq_mask_i` bit are both 1.
- R12: While `rx_en_i` is 0 no character is received. `fifo_rst_i` discards every stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample strobe at 16x the bit rate |
| rxd_i | input | 1 | Serial receive line, idle high |
| rx_en_i | input | 1 | Receiver enable |
| char_len_i | input | 2 | Data bits code: 0..3 means 5..8 bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 expects odd parity, 0 expects even |
| two_stop_i | input | 1 | 1 expects two stop bits |
| fifo_rst_i | input | 1 | Empties the queue and clears overrun |
| pop_i | input | 1 | Removes the head entry |
| thresh_i | input | 5 | Fill threshold for status bit 1 |
| tmo_chars_i | input | 4 | Timeout in character times, 0 disables |
| irq_mask_i | input | 3 | Per-event interrupt mask |
| rd_word_o | output | 12 | Head entry: valid, ferr, perr, break, data[7:0] |
| not_empty_o | output | 1 | Queue holds at least one entry |
| irq_stat_o | output | 3 | Raw status: bit0 overrun, bit1 threshold, bit2 timeout |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench goes after the frame-shape corners. It covers every data length including 5 bits, both parity senses with good and corrupted parity bits, and two stop bits. A receiver that miscounted bits would shift the data or flag spurious parity errors. It sends a held-low break and a low stop bit with nonzero data. A design that confused the two would tag the break as a framing error or store extra zero characters while the line stays low. It fills the queue past 16 to prove that the new character is lost rather than an old one, and that pops leave overrun set until a queue reset. It also times the stale-data event on either side of one character time, and checks that it clears on a pop or stays silent when disabled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W  = 8;
  localparam int WORD_W  = 12;
  localparam int NUM_EVT = 3;
  localparam int EVT_OVR = 0;
  localparam int EVT_THR = 1;
  localparam int EVT_TMO = 2;

  typedef struct packed {
    logic              valid;
    logic              ferr;
    logic              perr;
    logic              brk;
    logic [DATA_W-1:0] data;
  } rx_word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_HOLD
  } rx_state_t;
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       rx_en_i,
  input  logic [1:0] char_len_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       two_stop_i,
  output logic       push_o,
  output rx_word_t   word_o
);
  logic [1:0]        sync_q;
  logic              rxs;
  rx_state_t         state_q;
  logic [3:0]        os_q;
  logic [2:0]        idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_acc_q, perr_q, ferr_q, low_q;
  logic [2:0]        last_idx;

  assign rxs      = sync_q[1];
  assign last_idx = {1'b1, char_len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      os_q      <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      par_acc_q <= 1'b0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      low_q     <= 1'b0;
      push_o    <= 1'b0;
      word_o    <= '0;
    end else begin
      push_o <= 1'b0;
      if (!rx_en_i) begin
        state_q <= S_IDLE;
      end else if (tick_i) begin
        case (state_q)
          S_IDLE: if (!rxs) begin
            state_q <= S_START;
            os_q    <= '0;
          end
          S_START: begin
            if (os_q == 4'd7) begin
              os_q <= '0;
              if (rxs) state_q <= S_IDLE;  // glitch
              else begin
                state_q   <= S_DATA;
                idx_q     <= '0;
                shift_q   <= '0;
                par_acc_q <= 1'b0;
                perr_q    <= 1'b0;
                low_q     <= 1'b1;
              end
            end else os_q <= os_q + 4'd1;
          end
          S_DATA: begin
            if (os_q == 4'd15) begin
              os_q           <= '0;
              shift_q[idx_q] <= rxs;
              par_acc_q      <= par_acc_q ^ rxs;
              low_q          <= low_q & ~rxs;
              if (idx_q == last_idx) state_q <= par_en_i ? S_PAR : S_STOP1;
              else                   idx_q   <= idx_q + 3'd1;
            end else os_q <= os_q + 4'd1;
          end
          S_PAR: begin
            if (os_q == 4'd15) begin
              os_q    <= '0;
              perr_q  <= (par_acc_q ^ rxs) != par_odd_i;
              low_q   <= low_q & ~rxs;
              state_q <= S_STOP1;
            end else os_q <= os_q + 4'd1;
          end
          S_STOP1: begin
            if (os_q == 4'd15) begin
              os_q <= '0;
              if (low_q && !rxs) begin
                push_o  <= 1'b1;
                word_o  <= '{valid: 1'b1, ferr: 1'b0, perr: 1'b0, brk: 1'b1, data: '0};
                state_q <= S_HOLD;
              end else if (two_stop_i) begin
                ferr_q  <= ~rxs;
                state_q <= S_STOP2;
              end else begin
                push_o  <= 1'b1;
                word_o  <= '{valid: 1'b1, ferr: ~rxs, perr: perr_q, brk: 1'b0, data: shift_q};
                state_q <= rxs ? S_IDLE : S_HOLD;
              end
            end else os_q <= os_q + 4'd1;
          end
          S_STOP2: begin
            if (os_q == 4'd15) begin
              os_q    <= '0;
              push_o  <= 1'b1;
              word_o  <= '{valid: 1'b1, ferr: ferr_q | ~rxs, perr: perr_q, brk: 1'b0, data: shift_q};
              state_q <= rxs ? S_IDLE : S_HOLD;
            end else os_q <= os_q + 4'd1;
          end
          S_HOLD: if (rxs) state_q <= S_IDLE;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  p_push_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);
  p_brk_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && word_o.brk) |-> (word_o.data == '0 && !word_o.ferr && !word_o.perr));
  p_rx_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !push_o);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 12,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  level_o,
  output logic              push_ok_o,
  output logic              pop_ok_o,
  output logic              drop_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, empty;

  assign full      = cnt_q == CNT_W'(DEPTH);
  assign empty     = cnt_q == '0;
  assign push_ok_o = push_i && !full && !clear_i;
  assign pop_ok_o  = pop_i && !empty && !clear_i;
  assign drop_o    = push_i && full && !clear_i;
  assign level_o   = cnt_q;
  assign rdata_o   = empty ? '0 : mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok_o) wr_q <= nxt(wr_q);
      if (pop_ok_o)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_ok_o) - CNT_W'(pop_ok_o);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_drop_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && !pop_i) |=> (cnt_q == CNT_W'(DEPTH)));
  p_clear_empty_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
  import uart_rx_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int TMO_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [CNT_W-1:0]   level_i,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic               drop_i,
  input  logic               clear_i,
  input  logic [CNT_W-1:0]   thresh_i,
  input  logic [TMO_W-1:0]   tmo_chars_i,
  input  logic [1:0]         char_len_i,
  input  logic               par_en_i,
  input  logic               two_stop_i,
  input  logic [NUM_EVT-1:0] mask_i,
  output logic [NUM_EVT-1:0] stat_o,
  output logic               irq_o
);
  logic             ovr_q, tmo_q;
  logic [7:0]       tick_cnt_q;
  logic [TMO_W-1:0] chr_cnt_q;
  logic [3:0]       bits_per_char;
  logic [7:0]       char_ticks;
  logic [NUM_EVT-1:0] masked;

  assign bits_per_char = 4'd7 + {2'b00, char_len_i} + {3'b000, par_en_i} + {3'b000, two_stop_i};
  assign char_ticks    = {bits_per_char, 4'b0000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovr_q <= 1'b0;
    else if (clear_i) ovr_q <= 1'b0;
    else if (drop_i)  ovr_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt_q <= '0;
      chr_cnt_q  <= '0;
      tmo_q      <= 1'b0;
    end else if (clear_i || level_i == '0 || push_i || pop_i) begin
      tick_cnt_q <= '0;
      chr_cnt_q  <= '0;
      tmo_q      <= 1'b0;
    end else begin
      if (tick_i) begin
        if (tick_cnt_q == char_ticks - 8'd1) begin
          tick_cnt_q <= '0;
          if (chr_cnt_q != '1) chr_cnt_q <= chr_cnt_q + TMO_W'(1);
        end else tick_cnt_q <= tick_cnt_q + 8'd1;
      end
      if (tmo_chars_i != '0 && chr_cnt_q >= tmo_chars_i) tmo_q <= 1'b1;
    end
  end

  assign stat_o[EVT_OVR] = ovr_q;
  assign stat_o[EVT_THR] = level_i > thresh_i;
  assign stat_o[EVT_TMO] = tmo_q;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_mask
    assign masked[g] = stat_o[g] & mask_i[g];
  end
  assign irq_o = |masked;

  p_ovr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !clear_i) |=> ovr_q);
  p_tmo_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |=> !tmo_q);
  p_irq_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);
endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq
  import uart_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TMO_W  = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               rxd_i,
  input  logic               rx_en_i,
  input  logic [1:0]         char_len_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  input  logic               two_stop_i,
  input  logic               fifo_rst_i,
  input  logic               pop_i,
  input  logic [CNT_W-1:0]   thresh_i,
  input  logic [TMO_W-1:0]   tmo_chars_i,
  input  logic [NUM_EVT-1:0] irq_mask_i,
  output logic [WORD_W-1:0]  rd_word_o,
  output logic               not_empty_o,
  output logic [NUM_EVT-1:0] irq_stat_o,
  output logic               irq_o
);
  logic             fr_push;
  rx_word_t         fr_word;
  logic [CNT_W-1:0] level;
  logic             push_ok, pop_ok, drop;

  uart_rx_frame u_frame (
    .clk_i, .rst_ni, .tick_i, .rxd_i, .rx_en_i, .char_len_i,
    .par_en_i, .par_odd_i, .two_stop_i,
    .push_o (fr_push),
    .word_o (fr_word)
  );

  uart_rx_queue #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_queue (
    .clk_i, .rst_ni,
    .clear_i   (fifo_rst_i),
    .push_i    (fr_push),
    .wdata_i   (fr_word),
    .pop_i     (pop_i),
    .rdata_o   (rd_word_o),
    .level_o   (level),
    .push_ok_o (push_ok),
    .pop_ok_o  (pop_ok),
    .drop_o    (drop)
  );

  uart_rx_irq #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_irq (
    .clk_i, .rst_ni, .tick_i,
    .level_i     (level),
    .push_i      (push_ok),
    .pop_i       (pop_ok),
    .drop_i      (drop),
    .clear_i     (fifo_rst_i),
    .thresh_i    (thresh_i),
    .tmo_chars_i (tmo_chars_i),
    .char_len_i  (char_len_i),
    .par_en_i    (par_en_i),
    .two_stop_i  (two_stop_i),
    .mask_i      (irq_mask_i),
    .stat_o      (irq_stat_o),
    .irq_o       (irq_o)
  );

  assign not_empty_o = level != '0;

  p_valid_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_empty_o |-> rd_word_o[WORD_W-1]);
endmodule

// File: tb/uart_rx_fifo_irq_bench.sv
module uart_rx_fifo_irq_bench;
  localparam int BIT_CLK = 64;

  // {len[1:0], par_en, par_odd, two_stop, bad_par, data[7:0], expected word[11:0]}
  localparam logic [25:0] VECS [0:7] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 12'h8A5},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3F, 12'h81F},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 12'h855},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01, 12'h801},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 8'h03, 12'hA03},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80, 12'hA80},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h2A, 12'h82A},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 12'h8FF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        rxd = 1'b1;
  logic        rx_en = 1'b1;
  logic [1:0]  char_len = 2'd3;
  logic        par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic        fifo_rst = 1'b0, pop = 1'b0;
  logic [4:0]  thresh = 5'd16;
  logic [3:0]  tmo_chars = 4'd0;
  logic [2:0]  irq_mask = 3'b000;
  logic [11:0] rd_word;
  logic        not_empty, irq;
  logic [2:0]  irq_stat;
  logic [1:0]  tick_div = '0;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    tick_div <= tick_div + 2'd1;
    tick     <= (tick_div == 2'd3);
  end

  uart_rx_fifo_irq u_uart_rx_fifo_irq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .rx_en_i(rx_en),
    .char_len_i(char_len), .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop),
    .fifo_rst_i(fifo_rst), .pop_i(pop), .thresh_i(thresh), .tmo_chars_i(tmo_chars),
    .irq_mask_i(irq_mask), .rd_word_o(rd_word), .not_empty_o(not_empty),
    .irq_stat_o(irq_stat), .irq_o(irq)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pe, input bit pb,
                      input int nstop, input bit stop_v);
    rxd = 1'b0; wait_clk(BIT_CLK);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; wait_clk(BIT_CLK); end
    if (pe) begin rxd = pb; wait_clk(BIT_CLK); end
    for (int i = 0; i < nstop; i++) begin rxd = stop_v; wait_clk(BIT_CLK); end
    rxd = 1'b1; wait_clk(16);
  endtask

  task automatic send8(input logic [7:0] d);
    send(d, 8, 1'b0, 1'b0, 1, 1'b1);
  endtask

  task automatic do_pop();
    pop = 1'b1; wait_clk(1); pop = 1'b0;
  endtask

  task automatic do_flush();
    fifo_rst = 1'b1; wait_clk(1); fifo_rst = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    // R1 reset state
    chk("R1 word", rd_word, 0);
    chk("R1 not_empty", not_empty, 0);
    chk("R1 stat", irq_stat, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    wait_clk(5);

    // R2 R3 R4 R7 vector walk
    for (int i = 0; i < 8; i++) begin
      logic [25:0] v;
      logic [7:0]  dm;
      int          nb;
      bit          pb;
      v = VECS[i];
      char_len = v[25:24]; par_en = v[23]; par_odd = v[22]; two_stop = v[21];
      nb = 5 + int'(v[25:24]);
      dm = v[19:12] & 8'((1 << nb) - 1);
      pb = (^dm) ^ v[22] ^ v[20];
      wait_clk(4);
      send(v[19:12], nb, v[23], pb, v[21] ? 2 : 1, 1'b1);
      chk($sformatf("R2 R3 R4 vec%0d word", i), rd_word, v[11:0]);
      chk($sformatf("R7 vec%0d not_empty", i), not_empty, 1);
      do_pop();
      chk($sformatf("R7 vec%0d empty after pop", i), not_empty, 0);
    end
    char_len = 2'd3; par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    wait_clk(4);

    // R4 framing error: stop bit low
    send(8'h41, 8, 1'b0, 1'b0, 1, 1'b0);
    chk("R4 framing word", rd_word, 12'hC41);
    do_pop();

    // R5 break
    rxd = 1'b0; wait_clk(BIT_CLK * 14); rxd = 1'b1; wait_clk(BIT_CLK);
    chk("R5 break word", rd_word, 12'h900);
    do_pop();
    chk("R5 single entry", not_empty, 0);

    // R6 glitch rejection
    rxd = 1'b0; wait_clk(8); rxd = 1'b1; wait_clk(BIT_CLK * 12);
    chk("R6 glitch no entry", not_empty, 0);

    // R12 receiver disabled
    rx_en = 1'b0; send8(8'h5A); rx_en = 1'b1; wait_clk(4);
    chk("R12 disabled no entry", not_empty, 0);

    // R9 R11 threshold
    thresh = 5'd2; irq_mask = 3'b010;
    send8(8'h01); send8(8'h02);
    chk("R9 at threshold", irq_stat[1], 0);
    chk("R11 irq low", irq, 0);
    send8(8'h03);
    chk("R9 above threshold", irq_stat[1], 1);
    chk("R11 irq high", irq, 1);
    irq_mask = 3'b101; wait_clk(1);
    chk("R11 masked off", irq, 0);
    // R12 reset discards
    do_flush();
    chk("R12 flush empty", not_empty, 0);
    chk("R12 flush word", rd_word, 0);
    chk("R9 clear after flush", irq_stat[1], 0);

    // R8 overrun
    thresh = 5'd16; irq_mask = 3'b001;
    for (int i = 0; i < 16; i++) send8(8'(8'h10 + i));
    chk("R8 full no overrun", irq_stat[0], 0);
    send8(8'hEE);
    chk("R8 overrun set", irq_stat[0], 1);
    chk("R11 overrun irq", irq, 1);
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R7 R8 order %0d", i), rd_word, 12'h800 | 12'(8'h10 + i));
      do_pop();
    end
    chk("R8 drained empty", not_empty, 0);
    chk("R8 overrun survives pops", irq_stat[0], 1);
    do_flush();
    chk("R8 overrun cleared by reset", irq_stat[0], 0);

    // R10 timeout
    tmo_chars = 4'd1; irq_mask = 3'b100;
    send8(8'h77);
    wait_clk(200);
    chk("R10 before char time", irq_stat[2], 0);
    wait_clk(500);
    chk("R10 after char time", irq_stat[2], 1);
    chk("R11 timeout irq", irq, 1);
    do_pop();
    chk("R10 cleared by pop", irq_stat[2], 0);
    tmo_chars = 4'd0;
    send8(8'h78);
    wait_clk(1500);
    chk("R10 disabled", irq_stat[2], 0);
    do_pop();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule